// File: doc/BRIEF.md
# Grouped-priority interrupt masking arbiter

This block holds the per-line state of a small interrupt controller and decides, in every cycle, whether one pending request may interrupt the processor. Each line has an enable bit, a pending bit, an active bit and a priority byte. Only the top bits of the priority byte are stored. A three-bit grouping code splits every priority byte into a preemption part and a subpriority part. Among pending and enabled lines, the most urgent one is chosen. It is signalled with a one-cycle take strobe only when its preemption part is strictly better than the running level.

The running level combines four things. It starts from the preemption part of the most urgent active handler. Three masks can raise it: a global mask that forces it to 0, a fault mask that forces it to -1, and a threshold register that, when nonzero, caps it at its own value. An exception-return pulse retires the running handler and clears the fault mask. All state is reached through a small register bank with byte enables. Software and the hardware request lines set pending bits, and a taken line becomes active on the next edge.

Top module: `irq_preempt_arb`

## Requirements
- R1: A priority byte keeps only its upper PRIO_BITS (4) bits, and the lower bits read as zero, so writing 0xFF reads back 0xF0. Line 4k+j lives in bits [8j+7:8j] of word 8+k. A write changes only the bytes whose byte enable is set.
- R2: Writing word 0 sets enable bits and writing word 1 clears them, bit i standing for line i. Both words read the enable vector. Zero bits in the written data leave enable bits unchanged.
- R3: Words 2 and 3 set and clear pending bits in the same way, and both read the pending vector. A high `irq_req` bit sets its pending bit, and a set on the same edge beats a clear.
- R4: Among lines that are both pending and enabled, the winner has the numerically lowest priority byte. On a tie, the lowest line number wins.
- R5: The grouping code g sits in word 5 bits [2:0]. The preemption part of a byte is its bits [7:g+1]: g=7 leaves no preemption bits, and g of 3 or less makes all four stored bits preemption bits. Changing g while requests are pending changes the take decision in the same cycle.
- R6: `take_o` is high in the same cycle that the winner's preemption part is strictly below the running level. On the next edge that line becomes active and its pending bit clears, unless `irq_req` sets it again.
- R7: `run_prio_o` (signed) is the minimum of several terms: 256 when nothing applies, the preemption part of the most urgent active line, the threshold when it is nonzero, 0 under the global mask, and -1 under the fault mask.
- R8: The global mask (word 5 bit 8) blocks every take.
- R9: The fault mask (word 5 bit 9) blocks every take and drives `run_prio_o` to -1. An `exc_ret` pulse clears it, taking precedence over a write on the same edge.
- R10: The threshold (word 5 bits [23:16], upper 4 bits stored) blocks every line whose preemption part is greater than or equal to it. A threshold of 0 masks nothing.
- R11: `exc_ret` clears the active bit of the running handler, which is the active line with the lowest byte and then the lowest number. No take happens in that cycle.
- R12: After reset, all registers read zero, `take_o` is low and `run_prio_o` is 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Word address |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_req | input | N_IRQ (8) | Hardware request lines; a high bit sets its pending bit |
| exc_ret | input | 1 | Exception-return pulse |
| take_o | output | 1 | Take strobe for the winning line |
| irq_id_o | output | IDW (3) | Number of the winning line |
| run_prio_o | output | 10 (signed) | Current running level |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- a taken line is pending and enabled, and becomes active on the next edge;
- a take never occurs under either mask or above the threshold;
- a nested take is strictly better than the running handler;
- a return clears the fault mask and the handler it retires.

Only the bench's scenarios can show which line wins among ties, and that the read-back truncates priority bytes and honours byte enables. The same holds for how the grouping code moves the preemption boundary while requests wait, and for the exact running level produced by each combination of masks and active handlers.

// File: rtl/ipa_pkg.sv
// Shared constants and helpers of the grouped-priority arbiter.
// Assumes an 8-bit priority byte and a 3-bit grouping code.
package ipa_pkg;
    localparam int W_EN_SET   = 0;
    localparam int W_EN_CLR   = 1;
    localparam int W_PND_SET  = 2;
    localparam int W_PND_CLR  = 3;
    localparam int W_ACTIVE   = 4;
    localparam int W_CTRL     = 5;
    localparam int W_PRIO0    = 8;
    localparam int LVL_W      = 10;
    localparam logic signed [LVL_W-1:0] LVL_IDLE = 10'sd256;

    // Byte mask that keeps the preemption bits [7:grp+1].
    function automatic logic [7:0] preempt_mask(input logic [2:0] grp);
        logic [8:0] t;
        t = 9'h1FF << (int'(grp) + 1);
        return t[7:0];
    endfunction
endpackage

// File: rtl/ipa_regs.sv
// Register bank: enable, pending, active, control and priority storage.
// Assumes N_IRQ is a multiple of 4 and at most 32, and PRIO_BITS < 8.
module ipa_regs #(
    parameter int N_IRQ     = 8,
    parameter int PRIO_BITS = 4,
    parameter int AW        = 4,
    parameter int IDW       = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [3:0]            be,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic [N_IRQ-1:0]      hw_req,
    input  logic                  take,
    input  logic [IDW-1:0]        take_id,
    input  logic                  ret,
    input  logic                  ret_found,
    input  logic [IDW-1:0]        ret_id,
    output logic [N_IRQ-1:0]      en_q,
    output logic [N_IRQ-1:0]      pend_q,
    output logic [N_IRQ-1:0]      act_q,
    output logic [N_IRQ-1:0][7:0] prio_byte,
    output logic [2:0]            grp_q,
    output logic                  gmask_q,
    output logic                  fmask_q,
    output logic [7:0]            bp_byte
);
    localparam int NW = N_IRQ / 4;
    localparam int SH = 8 - PRIO_BITS;

    logic [31:0]          wmask, wbits;
    logic [N_IRQ-1:0]     take_oh, ret_oh;
    logic [PRIO_BITS-1:0] bp_q;

    assign wmask   = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    assign wbits   = wdata & wmask;
    assign take_oh = take ? (N_IRQ'(1) << take_id) : '0;
    assign ret_oh  = (ret && ret_found) ? (N_IRQ'(1) << ret_id) : '0;
    assign bp_byte = 8'(bp_q) << SH;

    function automatic logic hit(input logic [AW-1:0] a, input int w);
        return a == AW'(w);
    endfunction

    // Enable bits: write-1-to-set and write-1-to-clear words.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else if (we && hit(addr, ipa_pkg::W_EN_SET)) en_q <= en_q | wbits[N_IRQ-1:0];
        else if (we && hit(addr, ipa_pkg::W_EN_CLR)) en_q <= en_q & ~wbits[N_IRQ-1:0];
    end

    // Pending bits: software set/clear, hardware set, clear on take; sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else pend_q <= (pend_q
                        & ~((we && hit(addr, ipa_pkg::W_PND_CLR)) ? wbits[N_IRQ-1:0] : '0)
                        & ~take_oh)
                       | ((we && hit(addr, ipa_pkg::W_PND_SET)) ? wbits[N_IRQ-1:0] : '0)
                       | hw_req;
    end

    // Active bits: set by a take, cleared for the retiring handler.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else act_q <= (act_q | take_oh) & ~ret_oh;
    end

    // Control word: grouping code, masks and threshold; return clears the fault mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= '0;
            gmask_q <= 1'b0;
            fmask_q <= 1'b0;
            bp_q    <= '0;
        end else begin
            if (we && hit(addr, ipa_pkg::W_CTRL) && be[0]) grp_q <= wdata[2:0];
            if (we && hit(addr, ipa_pkg::W_CTRL) && be[1]) gmask_q <= wdata[8];
            if (we && hit(addr, ipa_pkg::W_CTRL) && be[2]) bp_q <= wdata[23 -: PRIO_BITS];
            if (ret) fmask_q <= 1'b0;
            else if (we && hit(addr, ipa_pkg::W_CTRL) && be[1]) fmask_q <= wdata[9];
        end
    end

    // One truncated priority field per line, packed four to a word.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_prio
        localparam int K = i / 4;
        localparam int J = i % 4;
        logic [PRIO_BITS-1:0] prio_q;
        // Byte-lane write of the stored upper bits.
        always_ff @(posedge clk) begin
            if (!rst_n) prio_q <= '0;
            else if (we && hit(addr, ipa_pkg::W_PRIO0 + K) && be[J])
                prio_q <= wdata[8*J+7 -: PRIO_BITS];
        end
        assign prio_byte[i] = 8'(prio_q) << SH;
    end

    // Read multiplexer for the addressed word.
    always_comb begin
        rdata = '0;
        if (hit(addr, ipa_pkg::W_EN_SET) || hit(addr, ipa_pkg::W_EN_CLR)) rdata = 32'(en_q);
        else if (hit(addr, ipa_pkg::W_PND_SET) || hit(addr, ipa_pkg::W_PND_CLR)) rdata = 32'(pend_q);
        else if (hit(addr, ipa_pkg::W_ACTIVE)) rdata = 32'(act_q);
        else if (hit(addr, ipa_pkg::W_CTRL))
            rdata = {8'h00, bp_byte, 6'b0, fmask_q, gmask_q, 5'b0, grp_q};
        else begin
            for (int k = 0; k < NW; k++)
                if (hit(addr, ipa_pkg::W_PRIO0 + k))
                    for (int j = 0; j < 4; j++) rdata[8*j +: 8] = prio_byte[4*k+j];
        end
    end
endmodule

// File: rtl/ipa_pick.sv
// Picks the most urgent line of a candidate set: lowest byte, then lowest number.
// Assumes priority bytes are comparable as unsigned values.
module ipa_pick #(
    parameter int N_IRQ = 8,
    parameter int IDW   = 3
) (
    input  logic [N_IRQ-1:0]      cand,
    input  logic [N_IRQ-1:0][7:0] bytes,
    output logic                  found,
    output logic [IDW-1:0]        idx,
    output logic [7:0]            best
);
    // Linear scan; a strict compare keeps the lower number on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = 8'hFF;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand[i] && (!found || bytes[i] < best)) begin
                found = 1'b1;
                best  = bytes[i];
                idx   = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/ipa_level.sv
// Running level: active handler's preemption part folded with the three masks.
// Assumes the level is signed so that the fault mask can express -1.
module ipa_level (
    input  logic                                act_found,
    input  logic [7:0]                          act_byte,
    input  logic [7:0]                          pmask,
    input  logic                                gmask,
    input  logic                                fmask,
    input  logic [7:0]                          bp_byte,
    output logic signed [ipa_pkg::LVL_W-1:0]    level
);
    logic signed [ipa_pkg::LVL_W-1:0] act_lvl, bp_lvl;

    assign act_lvl = $signed({2'b00, act_byte & pmask});
    assign bp_lvl  = $signed({2'b00, bp_byte});

    // Minimum over the contributing terms, fault mask last.
    always_comb begin
        level = ipa_pkg::LVL_IDLE;
        if (act_found && act_lvl < level) level = act_lvl;
        if (bp_byte != 8'h00 && bp_lvl < level) level = bp_lvl;
        if (gmask && level > 0) level = '0;
        if (fmask) level = -10'sd1;
    end
endmodule

// File: rtl/irq_preempt_arb.sv
// Top: register bank, winner pick, active pick, running level and take decision.
// Assumes exc_ret is a single-cycle pulse; a take is held off in that cycle.
module irq_preempt_arb #(
    parameter int N_IRQ     = 8,
    parameter int PRIO_BITS = 4,
    parameter int AW        = 4,
    localparam int IDW      = $clog2(N_IRQ)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_we,
    input  logic [AW-1:0]                      reg_addr,
    input  logic [3:0]                         reg_be,
    input  logic [31:0]                        reg_wdata,
    output logic [31:0]                        reg_rdata,
    input  logic [N_IRQ-1:0]                   irq_req,
    input  logic                               exc_ret,
    output logic                               take_o,
    output logic [IDW-1:0]                     irq_id_o,
    output logic signed [ipa_pkg::LVL_W-1:0]   run_prio_o
);
    logic [N_IRQ-1:0]      en_q, pend_q, act_q;
    logic [N_IRQ-1:0][7:0] prio_byte;
    logic [2:0]            grp_q;
    logic                  gmask, fmask;
    logic [7:0]            bp_byte, pmask;
    logic                  win_found, act_found;
    logic [IDW-1:0]        win_id, act_id;
    logic [7:0]            win_byte, act_byte, win_pre;

    ipa_regs #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .AW(AW), .IDW(IDW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .be(reg_be),
        .wdata(reg_wdata), .rdata(reg_rdata), .hw_req(irq_req),
        .take(take_o), .take_id(win_id), .ret(exc_ret), .ret_found(act_found),
        .ret_id(act_id), .en_q(en_q), .pend_q(pend_q), .act_q(act_q),
        .prio_byte(prio_byte), .grp_q(grp_q), .gmask_q(gmask), .fmask_q(fmask),
        .bp_byte(bp_byte)
    );

    ipa_pick #(.N_IRQ(N_IRQ), .IDW(IDW)) u_win (
        .cand(en_q & pend_q), .bytes(prio_byte),
        .found(win_found), .idx(win_id), .best(win_byte)
    );

    ipa_pick #(.N_IRQ(N_IRQ), .IDW(IDW)) u_run (
        .cand(act_q), .bytes(prio_byte),
        .found(act_found), .idx(act_id), .best(act_byte)
    );

    assign pmask   = ipa_pkg::preempt_mask(grp_q);
    assign win_pre = win_byte & pmask;

    ipa_level u_lvl (
        .act_found(act_found), .act_byte(act_byte), .pmask(pmask),
        .gmask(gmask), .fmask(fmask), .bp_byte(bp_byte), .level(run_prio_o)
    );

    // Take only on a strictly better preemption part and outside a return cycle.
    assign take_o   = win_found && !exc_ret && ($signed({2'b00, win_pre}) < run_prio_o);
    assign irq_id_o = win_id;
endmodule

// File: rtl/ipa_chk.sv
// Checker for the arbiter; bound into the top so it sees the internal state.
module ipa_chk #(
    parameter int N_IRQ = 8,
    parameter int IDW   = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  take_o,
    input logic [IDW-1:0]        irq_id_o,
    input logic                  exc_ret,
    input logic [N_IRQ-1:0]      en_q,
    input logic [N_IRQ-1:0]      pend_q,
    input logic [N_IRQ-1:0]      act_q,
    input logic                  gmask,
    input logic                  fmask,
    input logic [7:0]            bp_byte,
    input logic [7:0]            pmask,
    input logic [7:0]            win_pre,
    input logic                  act_found,
    input logic [IDW-1:0]        act_id,
    input logic [7:0]            act_byte,
    input logic signed [9:0]     run_prio_o
);
    AST_TAKE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (en_q[irq_id_o] && pend_q[irq_id_o])); // R6
    AST_TAKE_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> act_q[$past(irq_id_o)]); // R6
    AST_STRICT_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && act_found) |-> (win_pre < (act_byte & pmask))); // R6
    AST_GLOBAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |-> !take_o); // R8
    AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        fmask |-> (run_prio_o == -10'sd1 && !take_o)); // R9
    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ret |=> !fmask); // R9
    AST_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && bp_byte != 8'h00) |-> (win_pre < bp_byte)); // R10
    AST_RET_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ret && act_found) |=> !act_q[$past(act_id)]); // R11
endmodule

bind irq_preempt_arb ipa_chk #(.N_IRQ(N_IRQ), .IDW(IDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .take_o(take_o), .irq_id_o(irq_id_o), .exc_ret(exc_ret),
    .en_q(en_q), .pend_q(pend_q), .act_q(act_q), .gmask(gmask), .fmask(fmask),
    .bp_byte(bp_byte), .pmask(pmask), .win_pre(win_pre), .act_found(act_found),
    .act_id(act_id), .act_byte(act_byte), .run_prio_o(run_prio_o)
);

// File: tb/test_irq_preempt_arb.sv
// Bench: cycle model built from the requirements plus directed corner scenarios.
module test_irq_preempt_arb;
    localparam int CLK_P = 10;
    localparam int N     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [3:0]        reg_be = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [N-1:0]      irq_req = '0;
    logic              exc_ret = 1'b0;
    logic              take_o;
    logic [2:0]        irq_id_o;
    logic signed [9:0] run_prio_o;

    int n_chk = 0, n_fail = 0;
    logic [31:0] lf = 32'h1234_5678;

    logic [7:0] m_en = '0, m_pend = '0, m_act = '0;
    logic [3:0] m_pr [N] = '{default: '0};
    logic [2:0] m_grp = '0;
    logic       m_gm = 1'b0, m_fm = 1'b0;
    logic [3:0] m_bp = '0;

    irq_preempt_arb i_irq_preempt_arb (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .exc_ret(exc_ret),
        .take_o(take_o), .irq_id_o(irq_id_o), .run_prio_o(run_prio_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    // Expected take, winner, running level and retiring line from the model.
    task automatic model_eval(output bit tk, output int wid, output int rl, output int rid, output bit rf);
        int pm, wb, ab;
        bit wf;
        pm = (255 >> (int'(m_grp) + 1)) << (int'(m_grp) + 1);
        wf = 0; wid = 0; wb = 0; rf = 0; rid = 0; ab = 0;
        for (int i = 0; i < N; i++) begin
            if (m_en[i] && m_pend[i] && (!wf || m_pr[i] * 16 < wb)) begin
                wf = 1; wb = m_pr[i] * 16; wid = i;
            end
            if (m_act[i] && (!rf || m_pr[i] * 16 < ab)) begin
                rf = 1; ab = m_pr[i] * 16; rid = i;
            end
        end
        rl = 256;
        if (rf && (ab & pm) < rl) rl = ab & pm;
        if (m_bp != 0 && m_bp * 16 < rl) rl = m_bp * 16;
        if (m_gm && rl > 0) rl = 0;
        if (m_fm) rl = -1;
        tk = wf && !exc_ret && ((wb & pm) < rl);
    endtask

    // One clock: check outputs against the model, then advance the model.
    task automatic tick();
        bit tk, rf;
        int wid, rl, rid;
        logic [7:0] nen, npend, nact, sv, cv;
        logic [31:0] wb;
        logic [3:0] npr [N];
        logic [2:0] ngrp;
        logic ngm, nfm;
        logic [3:0] nbp;
        #1;
        model_eval(tk, wid, rl, rid, rf);
        chk("R6 take strobe", int'(take_o), int'(tk));
        if (tk) chk("R4 winner number", int'(irq_id_o), wid);
        chk("R7 running level", int'(run_prio_o), rl);
        wb = reg_wdata & {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};
        nen = m_en; sv = '0; cv = '0;
        npr = m_pr; ngrp = m_grp; ngm = m_gm; nfm = m_fm; nbp = m_bp;
        if (reg_we) begin
            case (reg_addr)
                4'd0: nen = m_en | wb[7:0];
                4'd1: nen = m_en & ~wb[7:0];
                4'd2: sv = wb[7:0];
                4'd3: cv = wb[7:0];
                4'd5: begin
                    if (reg_be[0]) ngrp = reg_wdata[2:0];
                    if (reg_be[1]) begin ngm = reg_wdata[8]; nfm = reg_wdata[9]; end
                    if (reg_be[2]) nbp = reg_wdata[23:20];
                end
                4'd8, 4'd9: for (int j = 0; j < 4; j++)
                    if (reg_be[j]) npr[(int'(reg_addr) - 8) * 4 + j] = reg_wdata[8*j+4 +: 4];
                default: ;
            endcase
        end
        if (exc_ret) nfm = 1'b0;
        npend = (m_pend & ~cv & ~(tk ? 8'(1 << wid) : 8'h00)) | sv | irq_req;
        nact  = (m_act | (tk ? 8'(1 << wid) : 8'h00)) & ~((exc_ret && rf) ? 8'(1 << rid) : 8'h00);
        @(posedge clk);
        m_en = nen; m_pend = npend; m_act = nact; m_pr = npr;
        m_grp = ngrp; m_gm = ngm; m_fm = nfm; m_bp = nbp;
        #1;
    endtask

    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 4'(a); reg_be = be; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_be = '0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        reg_addr = 4'(a);
        #1;
        chk(tag, int'(reg_rdata), int'(exp));
    endtask

    task automatic look(input string tag, input int tk, input int id, input int rl);
        #1;
        chk(tag, int'(take_o), tk);
        if (tk != 0) chk(tag, int'(irq_id_o), id);
        chk(tag, int'(run_prio_o), rl);
    endtask

    task automatic cleanup();
        wr(5, 4'b0010, 32'h100);
        exc_ret = 1'b1;
        repeat (8) tick();
        exc_ret = 1'b0;
        wr(3, 4'hF, 32'hFF);
        wr(1, 4'hF, 32'hFF);
        wr(5, 4'b0110, 32'h0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12: reset state
        look("R12 reset outputs", 0, 0, 256);
        for (int a = 0; a < 10; a++) if (a != 6 && a != 7) rd_chk(a, 32'h0, "R12 reset register");

        // R1: every value of every byte reads back truncated
        for (int i = 0; i < N; i++)
            for (int v = 0; v < 16; v++) begin
                wr(8 + i / 4, 4'(1 << (i % 4)), 32'(v * 17) << (8 * (i % 4)));
                rd_chk(8 + i / 4, 32'(v * 17 & 8'hF0) << (8 * (i % 4)) |
                       (32'(v * 17 & 8'hF0) << (8 * (i % 4)) ^ 32'(0)) |
                       ({m_pr[(i/4)*4+3], 4'h0, m_pr[(i/4)*4+2], 4'h0, m_pr[(i/4)*4+1], 4'h0, m_pr[(i/4)*4], 4'h0}
                        & ~(32'hFF << (8 * (i % 4)))), "R1 byte readback");
            end
        wr(8, 4'hF, 32'hFFFF_FFFF);
        rd_chk(8, 32'hF0F0_F0F0, "R1 0xFF reads 0xF0");
        wr(8, 4'b0101, 32'h1234_5678);
        rd_chk(8, 32'hF030_F070, "R1 byte enables");

        // R2: enable set and clear words
        wr(0, 4'hF, 32'hA5); rd_chk(0, 32'hA5, "R2 set");
        wr(0, 4'hF, 32'h0);  rd_chk(1, 32'hA5, "R2 zero set ignored");
        wr(1, 4'hF, 32'h05); rd_chk(1, 32'hA0, "R2 clear");
        wr(1, 4'hF, 32'h0);  rd_chk(0, 32'hA0, "R2 zero clear ignored");
        wr(1, 4'hF, 32'hFF); rd_chk(0, 32'h0, "R2 clear all");

        // R3: pending set, clear, hardware set, set beats clear
        wr(2, 4'hF, 32'h3C); rd_chk(2, 32'h3C, "R3 set");
        wr(3, 4'hF, 32'h0C); rd_chk(3, 32'h30, "R3 clear");
        wr(3, 4'hF, 32'h0);  rd_chk(2, 32'h30, "R3 zero clear ignored");
        irq_req = 8'h81; tick(); irq_req = '0;
        rd_chk(2, 32'hB1, "R3 hardware set");
        irq_req = 8'h01; wr(3, 4'hF, 32'h01); irq_req = '0;
        rd_chk(2, 32'hB1, "R3 set beats clear");
        wr(3, 4'hF, 32'hFF); rd_chk(2, 32'h0, "R3 clear all");

        // R4: full tie resolves to the lowest number
        wr(5, 4'b0011, 32'h103);
        wr(8, 4'hF, 32'h5050_5050); wr(9, 4'hF, 32'h5050_5050);
        wr(2, 4'hF, 32'h6C); wr(0, 4'hF, 32'h6C);
        wr(5, 4'b0010, 32'h0);
        look("R4 tie lowest number", 1, 2, 256);
        tick();
        cleanup();

        // R5: group change while a request waits
        wr(5, 4'b0011, 32'h103);
        wr(8, 4'hF, 32'h0000_4060);
        wr(2, 4'hF, 32'h1); wr(0, 4'hF, 32'h1);
        wr(5, 4'b0010, 32'h0);
        look("R6 first take", 1, 0, 256);
        tick();
        look("R7 active level", 0, 0, 96);
        wr(5, 4'b0010, 32'h100);
        wr(2, 4'hF, 32'h2); wr(0, 4'hF, 32'h2);
        wr(5, 4'b0011, 32'h006);
        look("R5 one preemption bit blocks", 0, 0, 0);
        wr(5, 4'b0001, 32'h004);
        look("R5 three preemption bits allow", 1, 1, 96);
        tick();
        look("R7 nested level", 0, 0, 64);
        exc_ret = 1'b1; tick(); exc_ret = 1'b0;
        look("R11 return to outer handler", 0, 0, 96);
        exc_ret = 1'b1; tick(); exc_ret = 1'b0;
        look("R11 return to idle", 0, 0, 256);
        cleanup();

        // R9: fault mask level, blocking and clearing on return
        wr(5, 4'b0011, 32'h204);
        look("R9 fault level", 0, 0, -1);
        wr(2, 4'hF, 32'h4); wr(0, 4'hF, 32'h4);
        look("R9 fault mask blocks", 0, 0, -1);
        exc_ret = 1'b1; tick(); exc_ret = 1'b0;
        rd_chk(5, 32'h4, "R9 cleared by return");
        look("R9 take after clearing", 1, 2, 256);
        tick();
        cleanup();

        // R8: global mask blocks a ready line
        wr(5, 4'b0011, 32'h103);
        wr(2, 4'hF, 32'h8); wr(0, 4'hF, 32'h8);
        look("R8 global mask blocks", 0, 0, 0);
        cleanup();

        // R10: threshold edge
        wr(5, 4'b0011, 32'h103);
        wr(9, 4'b0010, 32'h5000);
        wr(2, 4'hF, 32'h20); wr(0, 4'hF, 32'h20);
        wr(5, 4'b0110, 32'h0050_0000);
        look("R10 equal to threshold blocked", 0, 0, 80);
        wr(5, 4'b0100, 32'h0060_0000);
        look("R10 below threshold taken", 1, 5, 96);
        tick();
        cleanup();

        // Sweep over every group code with pseudo-random priorities and requests
        for (int g = 0; g < 8; g++)
            for (int t = 0; t < 40; t++) begin
                logic [31:0] r;
                wr(5, 4'b0011, 32'h100 | 32'(g));
                wr(8, 4'hF, rnd());
                wr(9, 4'hF, rnd());
                wr(2, 4'hF, rnd() & 32'hFF);
                wr(0, 4'hF, rnd() & 32'hFF);
                r = rnd();
                wr(5, 4'b0110, (r[1:0] == 2'b00) ? {8'h00, r[15:8], 16'h0} : 32'h0);
                for (int c = 0; c < 6; c++) begin
                    r = rnd();
                    irq_req = r[7:0] & r[15:8] & r[23:16];
                    tick();
                end
                irq_req = '0;
                repeat (4) tick();
                cleanup();
            end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule